// File: doc/BRIEF.md
# Thread Block Dispatcher

This block splits a kernel launch across a set of compute cores. A kernel is described by its total thread count. The block works out how many fixed-size thread blocks that count needs. While the launch input is held high, it hands a block ID and a per-block thread count to every core that is ready. Several cores can be loaded in one clock cycle, and each of them gets its own consecutive ID.

Each core signals completion with a done pulse. The dispatcher then stops that core, holds it in reset for one cycle, and treats it as ready again, so remaining blocks keep flowing to free cores. When every block has reported completion, the kernel-done output goes high. A synchronous reset returns the block to its idle state before the next kernel.

Top module: `block_dispatcher`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `core_start` is all zero, `core_reset` is all ones and `kernel_done` is 0.
- R2: The number of blocks handed out for a launch equals `total_threads` divided by `TPB`, rounded up.
- R3: In one cycle, ready cores are served in ascending index order. Core indices and IDs are both counted from 0. When cores 0..k-1 are all ready at launch, core i receives block ID i on the first edge.
- R4: Each block ID from 0 to total blocks minus 1 is given to exactly one core start. No ID is repeated and none is skipped.
- R5: `core_threads` for a started core equals `TPB`, except for the block with the highest ID. That block receives `total_threads` modulo `TPB` when that value is non-zero.
- R6: Once every block has been handed out, further ready cores receive no start. With fewer blocks than cores, the upper cores never start.
- R7: A done pulse from a started core clears its start bit on the next edge and raises its reset bit for one cycle. After that the core is eligible for a new block.
- R8: `kernel_done` rises one edge after the completed-block count reaches the total block count, and never earlier. A launch with zero threads therefore raises it on the first edge.
- R9: While `launch` is low, no core is started and no done pulse is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch | input | 1 | Held high while the kernel runs |
| total_threads | input | THR_W | Kernel thread count, stable while launch is high |
| core_done | input | NUM_CORES | Per-core completion pulse |
| core_start | output | NUM_CORES | Per-core run request |
| core_reset | output | NUM_CORES | Per-core reset; high means the core is ready for a block |
| core_block_id | output | NUM_CORES*ID_W | Block ID per core, core 0 in the low bits |
| core_threads | output | NUM_CORES*TC_W | Threads in the block given to each core |
| kernel_done | output | 1 | All blocks have completed |

## Verification
The bench starts all cores together. A design that let every ready core read the same counter value would give duplicate IDs to cores 0 to 3 and skip the IDs after them. The bench therefore checks the first-edge IDs and keeps a table of every ID seen. Thread counts that are not a multiple of the block size test the short last block, which an off-by-one in the last-ID compare would give a full count or give to the wrong core. Launches smaller than the core count catch a design that dispatches past the total. A zero-thread launch and a held-low launch catch a design whose done flag or dispatch ignores those cases.

// File: rtl/disp_pkg.sv
package disp_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/blk_calc.sv
module blk_calc #(
  parameter int THR_W = 10,
  parameter int TPB   = 4,
  parameter int CNT_W = 9,
  parameter int TC_W  = 3
) (
  input  logic [THR_W-1:0] total_threads,
  output logic [CNT_W-1:0] total_blocks,
  output logic [TC_W-1:0]  last_threads
);
  import disp_pkg::*;
  localparam logic [THR_W-1:0] TPB_V = THR_W'(TPB);

  logic [THR_W-1:0] rem;

  always_comb begin
    total_blocks = CNT_W'(ceil_div(int'(total_threads), TPB));
    rem          = total_threads % TPB_V;
    last_threads = (rem == '0) ? TC_W'(TPB) : TC_W'(rem);
  end
endmodule

// File: rtl/disp_alloc.sv
module disp_alloc #(
  parameter int NC    = 4,
  parameter int CNT_W = 9
) (
  input  logic             en,
  input  logic [NC-1:0]    ready,
  input  logic [CNT_W-1:0] base,
  input  logic [CNT_W-1:0] limit,
  output logic [NC-1:0]    grant,
  output logic [CNT_W-1:0] ids [NC],
  output logic [CNT_W-1:0] next_cnt
);
  logic [CNT_W-1:0] run;

  // running value advances inside the loop so each ready core sees a fresh ID
  always_comb begin
    run = base;
    for (int i = 0; i < NC; i++) begin
      grant[i] = 1'b0;
      ids[i]   = run;
      if (en && ready[i] && (run < limit)) begin
        grant[i] = 1'b1;
        run      = run + 1'b1;
      end
    end
    next_cnt = run;
  end

  // R6
  always_comb begin
    grant_cap_chk: assert (!en || (base > limit) || (next_cnt <= limit));
  end
endmodule

// File: rtl/done_tally.sv
module done_tally #(
  parameter int NC    = 4,
  parameter int CNT_W = 9
) (
  input  logic [NC-1:0]    events,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < NC; i++) count = count + CNT_W'(events[i]);
  end
endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher #(
  parameter int NUM_CORES = 4,
  parameter int TPB       = 4,
  parameter int ID_W      = 8,
  parameter int THR_W     = 10,
  parameter int TC_W      = $clog2(TPB + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      launch,
  input  logic [THR_W-1:0]          total_threads,
  input  logic [NUM_CORES-1:0]      core_done,
  output logic [NUM_CORES-1:0]      core_start,
  output logic [NUM_CORES-1:0]      core_reset,
  output logic [NUM_CORES*ID_W-1:0] core_block_id,
  output logic [NUM_CORES*TC_W-1:0] core_threads,
  output logic                      kernel_done
);
  localparam int CNT_W = ID_W + 1;

  logic [CNT_W-1:0] disp_cnt, done_cnt;
  logic [CNT_W-1:0] total_blocks, alloc_next, done_inc;
  logic [TC_W-1:0]  last_threads;
  logic [NUM_CORES-1:0] grant, finish;
  logic [CNT_W-1:0] alloc_ids [NUM_CORES];
  logic [ID_W-1:0]  id_q  [NUM_CORES];
  logic [TC_W-1:0]  thr_q [NUM_CORES];

  blk_calc #(.THR_W(THR_W), .TPB(TPB), .CNT_W(CNT_W), .TC_W(TC_W)) u_calc (
    .total_threads(total_threads),
    .total_blocks (total_blocks),
    .last_threads (last_threads)
  );

  disp_alloc #(.NC(NUM_CORES), .CNT_W(CNT_W)) u_alloc (
    .en      (launch),
    .ready   (core_reset),
    .base    (disp_cnt),
    .limit   (total_blocks),
    .grant   (grant),
    .ids     (alloc_ids),
    .next_cnt(alloc_next)
  );

  assign finish = core_start & core_done;

  done_tally #(.NC(NUM_CORES), .CNT_W(CNT_W)) u_tally (
    .events(finish),
    .count (done_inc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_cnt    <= '0;
      done_cnt    <= '0;
      core_start  <= '0;
      core_reset  <= '1;
      kernel_done <= 1'b0;
      for (int i = 0; i < NUM_CORES; i++) begin
        id_q[i]  <= '0;
        thr_q[i] <= '0;
      end
    end else if (launch) begin
      disp_cnt    <= alloc_next;
      done_cnt    <= done_cnt + done_inc;
      kernel_done <= (done_cnt == total_blocks);
      for (int i = 0; i < NUM_CORES; i++) begin
        if (core_reset[i]) begin
          core_reset[i] <= 1'b0;
          if (grant[i]) begin
            core_start[i] <= 1'b1;
            id_q[i]       <= alloc_ids[i][ID_W-1:0];
            thr_q[i]      <= (alloc_ids[i] == total_blocks - 1'b1) ? last_threads : TC_W'(TPB);
          end
        end
        if (finish[i]) begin
          core_start[i] <= 1'b0;
          core_reset[i] <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_flat
    assign core_block_id[g*ID_W +: ID_W] = id_q[g];
    assign core_threads[g*TC_W +: TC_W]  = thr_q[g];
  end

  // R6
  dispatch_cap_chk: assert property (@(posedge clk) disable iff (rst)
    launch |-> disp_cnt <= total_blocks);
  // R8
  completion_order_chk: assert property (@(posedge clk) disable iff (rst)
    done_cnt <= disp_cnt);
  // R7
  start_reset_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (core_start & core_reset) == '0);
  // R4
  id_step_chk: assert property (@(posedge clk) disable iff (rst)
    (launch && $past(launch)) |->
      int'(disp_cnt) == int'($past(disp_cnt)) + $countones(core_start & ~$past(core_start)));
  // R8
  idle_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    kernel_done |-> core_start == '0);
  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(launch) && !$past(rst)) |-> $stable(disp_cnt) && $stable(done_cnt));
endmodule

// File: tb/block_dispatcher_tb.sv
`timescale 1ns/1ps
module block_dispatcher_tb;
  localparam int NC = 4, TPB = 4, ID_W = 8, THR_W = 10, TC_W = 3;
  localparam int NV = 6;
  localparam int V_THR  [NV] = '{13, 32, 5, 16, 1, 47};
  localparam int V_BLK  [NV] = '{ 4,  8, 2,  4, 1, 12};
  localparam int V_LAST [NV] = '{ 1,  4, 1,  4, 1,  3};

  logic clk = 0, rst = 1, launch = 0;
  logic [THR_W-1:0] total_threads = '0;
  logic [NC-1:0] core_done = '0;
  logic [NC-1:0] core_start, core_reset;
  logic [NC*ID_W-1:0] core_block_id;
  logic [NC*TC_W-1:0] core_threads;
  logic kernel_done;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  block_dispatcher #(.NUM_CORES(NC), .TPB(TPB), .ID_W(ID_W), .THR_W(THR_W)) u_dut (
    .clk(clk), .rst(rst), .launch(launch), .total_threads(total_threads),
    .core_done(core_done), .core_start(core_start), .core_reset(core_reset),
    .core_block_id(core_block_id), .core_threads(core_threads), .kernel_done(kernel_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; launch = 0; core_done = '0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic run_kernel(input int thr, input int blk, input int last, input int seed);
    bit seen [256];
    int cnt [NC];
    int lat [NC];
    bit done_q [NC];
    bit prev_start [NC];
    int n_started = 0, n_done = 0, cyc = 0, bad_seen = 0, bad_early = 0;
    for (int i = 0; i < 256; i++) seen[i] = 0;
    for (int i = 0; i < NC; i++) begin
      cnt[i] = 0; done_q[i] = 0; prev_start[i] = 0;
      lat[i] = 2 + ((i * 3 + seed) % 4);
    end
    do_reset();
    total_threads = THR_W'(thr);
    launch = 1;
    while (!kernel_done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < NC; i++) begin
        if (done_q[i]) // R7
          chk(!core_start[i] && core_reset[i], "R7", {core_start[i], core_reset[i]}, 1);
        if (core_start[i] && !prev_start[i]) begin
          int id = int'(core_block_id[i*ID_W +: ID_W]);
          int tc = int'(core_threads[i*TC_W +: TC_W]);
          int etc = (id == blk - 1) ? last : TPB;
          n_started++;
          if (cyc == 1) chk(id == i, "R3", id, i);
          if (id >= blk || seen[id]) begin
            bad_seen++;
            chk(0, "R4", id, blk);
          end else seen[id] = 1;
          chk(tc == etc, "R5", tc, etc);
        end
        prev_start[i] = core_start[i];
      end
      if (cyc == 1) // R6: cores beyond the block count stay idle
        for (int i = blk; i < NC; i++) chk(!core_start[i], "R6", core_start[i], 0);
      if (kernel_done && n_done < blk) bad_early++;
      for (int i = 0; i < NC; i++) begin
        if (done_q[i]) begin
          core_done[i] = 0; done_q[i] = 0; cnt[i] = 0;
        end else if (core_start[i]) begin
          cnt[i]++;
          if (cnt[i] >= lat[i]) begin
            core_done[i] = 1; done_q[i] = 1; n_done++;
          end
        end
      end
    end
    chk(bad_early == 0, "R8", bad_early, 0);
    chk(kernel_done == 1'b1, "R8", kernel_done, 1);
    chk(n_started == blk, "R2", n_started, blk);
    chk(bad_seen == 0, "R4", bad_seen, 0);
    launch = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk); @(negedge clk);
    chk(core_start == '0, "R1", core_start, 0);
    chk(core_reset == '1, "R1", core_reset, 15);
    chk(kernel_done == 0, "R1", kernel_done, 0);
    rst = 0;
    @(negedge clk);
    chk(core_reset == '1 && core_start == '0, "R1", core_reset, 15);
    // R9 launch low: no dispatch, done pulses ignored
    total_threads = 10'd20;
    core_done = '1;
    repeat (3) @(negedge clk);
    chk(core_start == '0, "R9", core_start, 0);
    chk(core_reset == '1, "R9", core_reset, 15);
    chk(kernel_done == 0, "R9", kernel_done, 0);
    core_done = '0;
    // table-driven kernels
    for (int v = 0; v < NV; v++) run_kernel(V_THR[v], V_BLK[v], V_LAST[v], v);
    // R8 zero threads: done on first edge, nothing started
    do_reset();
    total_threads = '0;
    launch = 1;
    @(negedge clk);
    chk(kernel_done == 1, "R8", kernel_done, 1);
    chk(core_start == '0, "R6", core_start, 0);
    launch = 0;
    // R3 full load: 4 cores all started on first edge with IDs 0..3
    do_reset();
    total_threads = 10'd100;
    launch = 1;
    @(negedge clk);
    chk(core_start == '1, "R3", core_start, 15);
    for (int i = 0; i < NC; i++)
      chk(int'(core_block_id[i*ID_W +: ID_W]) == i, "R3", int'(core_block_id[i*ID_W +: ID_W]), i);
    launch = 0;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule